// File: doc/BRIEF.md
# Auto-Reload 8-Bit Interval Timer

This block is a single 8-bit up-counter advanced by a one-cycle count-enable strobe. The strobe normally comes from a divider elsewhere on the chip. A control bit picks one of two behaviours when the counter steps past its top value:

- **Interval mode:** the counter wraps to zero.
- **Reload mode:** the counter restarts from a software-programmed start value. The time between overflows is then 256 minus that value, in count strobes, anywhere from 1 to 256.

Every overflow latches a sticky flag. The flag, gated by an enable bit, drives an interrupt line.

Software uses a small register window with a write strobe, a 2-bit address and a combinational read path:

- Writing the start value also places it in the live counter at once, so a new period takes effect without waiting for the next overflow.
- The counter can be read back.
- The flag is cleared by writing a one to its bit.

Top module: `reload_tmr8`

## Requirements
- R1: After reset the counter, start value, control bits and overflow flag all read zero and irq_o is low.
- R2: Each cycle with cnt_en_i high and no start-value write advances the counter (address 2, read-only) by one below 0xFF. Without cnt_en_i the counter holds its value.
- R3: A write to address 1 stores the start value and loads the same value into the counter on the next cycle, in either mode.
- R4: With control bit 0 (mode, at address 0) cleared, a count strobe at 0xFF gives 0x00, whatever start value is stored.
- R5: With control bit 0 set, a count strobe at 0xFF gives the stored start value instead of an increment.
- R6: Every count strobe at 0xFF sets the overflow flag (address 3, bit 0), in both modes.
- R7: Writing 1 to address 3 bit 0 clears the flag. Writing 0 leaves it set. An overflow in the same cycle as a clear leaves the flag set.
- R8: irq_o is high exactly when the flag is set and control bit 1 (interrupt enable) is set.
- R9: In reload mode, overflows recur every 256 minus start value strobes: every strobe for 0xFF, and every 256 strobes for 0x00.
- R10: A start-value write in the same cycle as a count strobe wins. The counter shows the written value, not incremented.
- R11: Writes to address 2 leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count strobe, one increment per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 start value, 2 counter, 3 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The counter is driven with the following patterns:

- **Short strobe bursts and idle gaps:** separate stepping from holding.
- **Bursts that cross 0xFF:** one burst in interval mode and one in reload mode, with a non-zero start value. This shows that the wrap target depends on the mode and not on the stored value.
- **Start values 0x80, 0xFF and 0x00:** the periods measured between flag events pin down the 256-minus-value rule at its middle and both extremes.
- **Start-value write while a strobe is high:** exposes the write-versus-count priority.
- **Status writes of zero and one:** tell a genuine one-to-clear apart from a clear on any write.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_addr_e;

  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int STAT_OVF_BIT  = 0;
endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] reload_o,
  output logic         mode_o,
  output logic         irq_en_o,
  output logic         reload_wr_o,
  output logic         flag_clr_o
);
  logic ctrl_wr;

  assign ctrl_wr     = wr_en_i && (addr_i == REG_CTRL);
  assign reload_wr_o = wr_en_i && (addr_i == REG_RELOAD);
  assign flag_clr_o  = wr_en_i && (addr_i == REG_STATUS) && wdata_i[STAT_OVF_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_o <= '0;
      mode_o   <= 1'b0;
      irq_en_o <= 1'b0;
    end else begin
      if (reload_wr_o) reload_o <= wdata_i;
      if (ctrl_wr) begin
        mode_o   <= wdata_i[CTRL_MODE_BIT];
        irq_en_o <= wdata_i[CTRL_IE_BIT];
      end
    end
  end
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  input  logic         mode_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_d;
  logic         at_top;

  assign at_top = (cnt_o == TOP);
  // a load in the same cycle suppresses the step, so no overflow then
  assign ovf_o  = cnt_en_i && !load_i && at_top;

  always_comb begin
    cnt_d = cnt_o;
    if (load_i)       cnt_d = load_val_i;
    else if (ovf_o)   cnt_d = mode_i ? reload_i : '0;
    else if (cnt_en_i) cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (ovf_i) flag_o <= 1'b1;   // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o && irq_en_i;
endmodule

// File: rtl/reload_tmr8.sv
module reload_tmr8
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] reload_q;
  logic         mode_q;
  logic         irq_en_q;
  logic         flag_q;
  logic         reload_wr;
  logic         flag_clr;
  logic         ovf;

  tmr8_regs #(.W(W)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .reload_o    (reload_q),
    .mode_o      (mode_q),
    .irq_en_o    (irq_en_q),
    .reload_wr_o (reload_wr),
    .flag_clr_o  (flag_clr)
  );

  tmr8_counter #(.W(W)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (cnt_en_i),
    .load_i     (reload_wr),
    .load_val_i (wdata_i),
    .reload_i   (reload_q),
    .mode_i     (mode_q),
    .cnt_o      (cnt_q),
    .ovf_o      (ovf)
  );

  tmr8_flag flag_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ovf_i    (ovf),
    .clr_i    (flag_clr),
    .irq_en_i (irq_en_q),
    .flag_o   (flag_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_MODE_BIT] = mode_q;
        rdata_o[CTRL_IE_BIT]   = irq_en_q;
      end
      REG_RELOAD: rdata_o = reload_q;
      REG_COUNT:  rdata_o = cnt_q;
      default:    rdata_o[STAT_OVF_BIT] = flag_q;
    endcase
  end
endmodule

// File: rtl/reload_tmr8_chk.sv
module reload_tmr8_chk
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic         wr_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic         irq_o,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] reload_q,
  input logic         mode_q,
  input logic         irq_en_q,
  input logic         flag_q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic ld, step, wrap;
  assign ld   = wr_en_i && (addr_i == REG_RELOAD);
  assign step = cnt_en_i && !ld;
  assign wrap = step && (cnt_q == TOP);

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && cnt_q != TOP |=> cnt_q == W'($past(cnt_q) + 1'b1));
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i && !ld |=> $stable(cnt_q));
  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> cnt_q == $past(wdata_i));
  // R4
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap && !mode_q |=> cnt_q == '0);
  // R5
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap && mode_q |=> cnt_q == $past(reload_q));
  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q);
  // R7
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == REG_STATUS && wdata_i[STAT_OVF_BIT] && !wrap |=> !flag_q);
  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_q |-> !irq_o);
endmodule

bind reload_tmr8 reload_tmr8_chk #(.W(W)) chk_i (.*);

// File: tb/reload_tmr8_tb_top.sv
`timescale 1ns/1ps
module reload_tmr8_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  reload_tmr8 dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {7'd0, irq_o} : rdata_o;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic wr_counting(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; cnt_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; cnt_en_i = 1'b0;
  endtask

  task automatic tick(input int n);
    @(posedge clk_i); #1;
    cnt_en_i = 1'b1;
    repeat (n) begin
      @(posedge clk_i); #1;
    end
    cnt_en_i = 1'b0;
  endtask

  task automatic chk(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    addr_i = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  // watchdog
  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk(2'd2, 8'h00, "R1 count");
    chk(2'd1, 8'h00, "R1 reload");
    chk(2'd0, 8'h00, "R1 ctrl");
    chk(2'd3, 8'h00, "R1 flag");
    chk_irq(1'b0, "R1 irq");

    // R2 step and hold
    tick(5);
    chk(2'd2, 8'h05, "R2 step");
    repeat (3) @(posedge clk_i);
    #1 chk(2'd2, 8'h05, "R2 hold");

    // R3 load in interval mode, R4 wrap to zero, R6 flag, R8 gated
    wr(2'd1, 8'hF0);
    chk(2'd2, 8'hF0, "R3 load interval");
    tick(15);
    chk(2'd2, 8'hFF, "R4 at top");
    chk(2'd3, 8'h00, "R6 no flag before wrap");
    tick(1);
    chk(2'd2, 8'h00, "R4 wrap zero");
    chk(2'd3, 8'h01, "R6 flag interval");
    chk_irq(1'b0, "R8 irq masked");

    // R8 enable with flag pending, reload mode
    wr(2'd0, 8'h03);
    chk(2'd0, 8'h03, "R8 ctrl readback");
    chk_irq(1'b1, "R8 irq on enable");

    // R7 clear semantics
    wr(2'd3, 8'h00);
    chk(2'd3, 8'h01, "R7 zero write keeps");
    wr(2'd3, 8'h01);
    chk(2'd3, 8'h00, "R7 one clears");
    chk_irq(1'b0, "R8 irq drops");

    // R5 and R9: reload 0x80, period 128
    wr(2'd1, 8'h80);
    chk(2'd2, 8'h80, "R3 load reload mode");
    tick(127);
    chk(2'd2, 8'hFF, "R9 127 strobes");
    chk(2'd3, 8'h00, "R9 no early flag");
    tick(1);
    chk(2'd2, 8'h80, "R5 reload on wrap");
    chk(2'd3, 8'h01, "R6 flag reload");
    chk_irq(1'b1, "R8 irq raised");
    wr(2'd3, 8'h01);

    // R10 write beats count
    wr_counting(2'd1, 8'h10);
    chk(2'd2, 8'h10, "R10 write priority");
    tick(1);
    chk(2'd2, 8'h11, "R2 after load");

    // R11 counter not writable
    wr(2'd2, 8'h55);
    chk(2'd2, 8'h11, "R11 count write ignored");

    // R9 start 0xFF: every strobe
    wr(2'd1, 8'hFF);
    tick(1);
    chk(2'd2, 8'hFF, "R9 ff reload");
    chk(2'd3, 8'h01, "R9 ff flag 1");
    wr(2'd3, 8'h01);
    tick(1);
    chk(2'd3, 8'h01, "R9 ff flag 2");
    wr(2'd3, 8'h01);

    // R9 start 0x00: 256 strobes
    wr(2'd1, 8'h00);
    tick(255);
    chk(2'd2, 8'hFF, "R9 00 at top");
    chk(2'd3, 8'h00, "R9 00 no early flag");
    tick(1);
    chk(2'd2, 8'h00, "R9 00 reload");
    chk(2'd3, 8'h01, "R9 00 flag");
    wr(2'd3, 8'h01);

    // R4 interval ignores stored start value
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    tick(192);
    chk(2'd2, 8'h00, "R4 wrap ignores start");
    chk(2'd3, 8'h01, "R6 flag interval again");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule